// File: doc/BRIEF.md
# Synthesizer Configuration Port

This block holds the divider and test settings of a clock synthesizer: a 7-bit feedback multiplier M, a 2-bit post-divide code N and a 3-bit test-select code T. The registers can be written in two ways. The first is a parallel capture of M and N from pins on a strobe. The second is a three-wire serial path: a clock, a data line and a load strobe. The serial path fills a 12-bit shift register, which is then copied into the registers.

All strobes and the serial clock are asynchronous to the block. They are brought into the system clock domain through synchronizer flops, and their edges are detected there. The parallel path always wins. While the parallel strobe is held low, serial loads are refused, so a board that keeps that strobe low through reset stays under pin control.

From the held M and a reference frequency given as a parameter, the block computes the oscillator frequency 2 × M × reference. It raises a flag when that value lies outside the allowed window.

Top module: `synth_cfg_port`

## Requirements
- R1: While reset is asserted, and after it until the first load, m_val is 127 (all ones), n_code is 3 (all ones) and t_sel is 0.
- R2: Each rising edge of ser_clk shifts ser_data into a 12-bit shift register, MSB first. The last 12 bits shifted are the ones used: the first 3 of them give T[2:0], the next 2 give N[1:0] and the last 7 give M[6:0]. Shifting alone does not change any output.
- R3: A falling edge of ser_load, while par_load is high, copies the shift register into t_sel, n_code and m_val.
- R4: A rising edge of par_load captures par_m into m_val and par_n into n_code. t_sel is left unchanged.
- R5: When a rising edge of par_load and a falling edge of ser_load are detected in the same cycle, the parallel values are taken and t_sel keeps its value.
- R6: A falling edge of ser_load while par_load is low has no effect on m_val, n_code or t_sel. The shifted bits are kept for a later load.
- R7: vco_oor is 1 exactly when 2 × m_val × REF_MHZ is below 800 or above 1800. Both limits count as in range. With REF_MHZ = 16, M = 25 and M = 56 are in range, and M = 24 and M = 57 are out of range.
- R8: When no load edge is detected, m_val, n_code and t_sel hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| par_load | input | 1 | Parallel capture strobe, rising edge active |
| par_m | input | 7 | Parallel feedback multiplier value |
| par_n | input | 2 | Parallel post-divide code |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Serial transfer strobe, falling edge active |
| m_val | output | 7 | Held feedback multiplier |
| n_code | output | 2 | Held post-divide code |
| t_sel | output | 3 | Held test-select code |
| vco_oor | output | 1 | Oscillator frequency outside the allowed window |

## Verification
Serial frames with distinct values in all three fields are checked against parallel captures that leave T untouched. This tells the field order apart and shows which path wrote which register. A 14-bit frame shows that only the last 12 bits count. A load refused while the parallel strobe is low is followed by a later accepted load, which shows that the shifted data was kept but not used. A parallel rise that falls in the same cycle as a serial load settles the priority. Parallel values of M at 24, 25, 56 and 57 place the edges of the range flag.

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
  parameter int M_W         = 7,
  parameter int N_W         = 2,
  parameter int T_W         = 3,
  parameter int REF_MHZ     = 16,
  parameter int VCO_MIN_MHZ = 800,
  parameter int VCO_MAX_MHZ = 1800,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           vco_oor
);
  localparam int SR_W = T_W + N_W + M_W;
  localparam int S    = SYNC_STAGES;

  logic [S:0]      pl_q, sc_q, sl_q;
  logic [S-1:0]    sd_q;
  logic [SR_W-1:0] shreg;
  logic            par_lvl, par_rise, ser_rise, ser_fall;
  logic [31:0]     vco_mhz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_q <= '0;
      sc_q <= '0;
      sl_q <= '0;
      sd_q <= '0;
    end else begin
      pl_q <= {pl_q[S-1:0], par_load};
      sc_q <= {sc_q[S-1:0], ser_clk};
      sl_q <= {sl_q[S-1:0], ser_load};
      sd_q <= {sd_q[S-2:0], ser_data};
    end
  end

  assign par_lvl  = pl_q[S-1];
  assign par_rise = pl_q[S-1] & ~pl_q[S];
  assign ser_rise = sc_q[S-1] & ~sc_q[S];
  assign ser_fall = ~sl_q[S-1] & sl_q[S];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (ser_rise)
      shreg <= {shreg[SR_W-2:0], sd_q[S-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_val  <= '1;
      n_code <= '1;
      t_sel  <= '0;
    end else if (par_rise) begin
      m_val  <= par_m;
      n_code <= par_n;
    end else if (ser_fall && par_lvl) begin
      {t_sel, n_code, m_val} <= shreg;
    end
  end

  assign vco_mhz = 32'(m_val) * 32'(2 * REF_MHZ);
  assign vco_oor = (vco_mhz < 32'(VCO_MIN_MHZ)) || (vco_mhz > 32'(VCO_MAX_MHZ));
endmodule

module synth_cfg_port_chk #(
  parameter int M_W  = 7,
  parameter int N_W  = 2,
  parameter int T_W  = 3,
  parameter int SR_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [M_W-1:0]  par_m,
  input logic [N_W-1:0]  par_n,
  input logic [M_W-1:0]  m_val,
  input logic [N_W-1:0]  n_code,
  input logic [T_W-1:0]  t_sel,
  input logic [SR_W-1:0] shreg,
  input logic            par_lvl,
  input logic            par_rise,
  input logic            ser_rise,
  input logic            ser_fall
);
  // R4
  par_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_rise |=> (m_val == $past(par_m)) && (n_code == $past(par_n)) && $stable(t_sel));

  // R3
  ser_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_fall && par_lvl && !par_rise) |=> ({t_sel, n_code, m_val} == $past(shreg)));

  // R6
  ser_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_lvl |=> $stable({t_sel, n_code, m_val}));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rise |=> (shreg[SR_W-1:1] == $past(shreg[SR_W-2:0])));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_rise && !ser_fall) |=> $stable({t_sel, n_code, m_val}));
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .SR_W(SR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n),
  .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .shreg(shreg),
  .par_lvl(par_lvl), .par_rise(par_rise), .ser_rise(ser_rise), .ser_fall(ser_fall)
);

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       par_load = 0, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [6:0] par_m = 7'h7f;
  logic [1:0] par_n = 2'h3;
  logic [6:0] m_val;
  logic [1:0] n_code;
  logic [2:0] t_sel;
  logic       vco_oor;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .vco_oor(vco_oor)
  );

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_oor(int m);
    return ((2 * m * 16) < 800 || (2 * m * 16) > 1800) ? 1 : 0;
  endfunction

  task automatic check_regs(string req, int m, int n, int t);
    check({req, " m_val"}, int'(m_val), m);
    check({req, " n_code"}, int'(n_code), n);
    check({req, " t_sel"}, int'(t_sel), t);
    check({req, " vco_oor R7"}, int'(vco_oor), exp_oor(m));
  endtask

  task automatic shift_bits(int nbits, logic [15:0] bits);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wcyc(3);
      ser_clk = 1;
      wcyc(4);
      ser_clk = 0;
      wcyc(4);
    end
  endtask

  task automatic ser_pulse();
    ser_load = 1;
    wcyc(5);
    ser_load = 0;
    wcyc(6);
  endtask

  task automatic par_write(logic [6:0] m, logic [1:0] n);
    par_load = 0;
    par_m = m;
    par_n = n;
    wcyc(5);
    par_load = 1;
    wcyc(6);
  endtask

  task automatic t_reset();
    wcyc(3);
    check_regs("R1 in reset", 127, 3, 0);
    rst_n = 1;
    wcyc(3);
    check_regs("R1 after reset", 127, 3, 0);
    par_load = 1;
    wcyc(6);
  endtask

  task automatic t_serial();
    shift_bits(12, {4'h0, 3'd5, 2'd1, 7'd40});
    check_regs("R2 shift only", 127, 3, 0);
    ser_pulse();
    check_regs("R3 serial load", 40, 1, 5);
  endtask

  task automatic t_parallel();
    par_write(7'd25, 2'd2);
    check_regs("R4 parallel 25", 25, 2, 5);
    par_write(7'd24, 2'd0);
    check_regs("R7 low edge 24", 24, 0, 5);
    par_write(7'd56, 2'd1);
    check_regs("R7 high edge 56", 56, 1, 5);
    par_write(7'd57, 2'd3);
    check_regs("R7 above 57", 57, 3, 5);
    wcyc(10);
    check_regs("R8 hold", 57, 3, 5);
  endtask

  task automatic t_ignore();
    par_load = 0;
    par_m = 7'd33;
    par_n = 2'd1;
    wcyc(5);
    shift_bits(12, {4'h0, 3'd2, 2'd0, 7'd30});
    ser_pulse();
    check_regs("R6 refused", 57, 3, 5);
    par_load = 1;
    wcyc(6);
    check_regs("R6 parallel after", 33, 1, 5);
    ser_pulse();
    check_regs("R6 kept bits", 30, 0, 2);
  endtask

  task automatic t_extra();
    shift_bits(14, {2'b0, 2'b11, 3'd3, 2'd3, 7'd50});
    ser_pulse();
    check_regs("R2 last twelve", 50, 3, 3);
  endtask

  task automatic t_priority();
    par_load = 0;
    par_m = 7'd45;
    par_n = 2'd0;
    wcyc(5);
    shift_bits(12, {4'h0, 3'd6, 2'd2, 7'd20});
    ser_load = 1;
    wcyc(5);
    par_load = 1;
    ser_load = 0;
    wcyc(6);
    check_regs("R5 priority", 45, 0, 3);
  endtask

  initial begin
    t_reset();
    t_serial();
    t_parallel();
    t_ignore();
    t_extra();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule